// File: doc/BRIEF.md
# Tributary Signal Crosspoint Switch

This block steers bundled low-speed tributaries (DS1 or E1 channels) from five source groups into the input channels of a jitter-attenuator bank. The five groups are an external line port, a framer, a demultiplexer, a test pattern generator and a virtual-tributary mapper. Each bundle carries a data byte, a clock enable, and four side signals: remote alarm (RAI), alarm indication (AIS), frame sync and out-of-band signaling. A receive pointer-adjust flag travels with the bundle only when the mapper is the source. Each destination channel owns one 8-bit selector byte. The selector names a group and a channel inside it.

Software writes selector bytes through a small synchronous register bus. Two bytes are packed in each 16-bit word. A write lands in a shadow copy that reads back exactly as written. The copy becomes the live routing only on a frame-boundary tick, so a channel never changes source inside a byte. A selector that points at the jitter-attenuator bank's own outputs would create a loop. Such a selector gives no path and raises a sticky per-channel error flag. Software can read that flag and clear it.

One control input picks the clock source of the external port. The external port can use its own input clock, or it can take the demultiplexer's recovered DS1 clock and drive that clock back out. Every routed signal passes through exactly one register stage, so the side signals stay aligned with the data.

Top module: `trib_xpoint`

## Requirements
- R1: While reset is asserted, every destination shows the idle bundle: data 8'hFF, AIS 1, and clock enable, RAI, frame sync, signaling and pointer-adjust 0. At the same time cfg_rdata is 0, ext_clk_out is 0, and all selectors read back as 0.
- R2: Register address a (0 to 13) holds the selector of destination 2a in bits [7:0] and the selector of destination 2a+1 in bits [15:8]. A selector byte has the group code in [7:5] and the channel number (1 to 29) in [4:0]. The group codes are 1 external port, 2 framer, 3 demultiplexer, 4 pattern generator, 5 mapper and 6 jitter-attenuator outputs. A read with cfg_rd high returns the stored word on cfg_rdata one cycle later, exactly as written. A read in the same cycle as a write returns the old contents.
- R3: For a connected selector, the destination's data, clock enable, RAI, AIS, frame sync and signaling equal the chosen source's values from the previous clock cycle.
- R4: A written selector takes effect only on a cycle with frame_tick high. If a write and a tick fall in the same cycle, the new value is committed by that tick. The first routed output appears one cycle after the tick.
- R5: A selector with channel 0, a channel above 29, or group code 0 or 7 leaves the destination unconnected, and the destination shows the idle bundle of R1.
- R6: Group code 6 creates no path, and the destination shows the idle bundle. When such a selector is committed by a tick, the destination's error flag is set. The flags for destinations 0 to 15 read at address 14, bits [15:0]. The flags for destinations 16 to 27 read at address 15, bits [11:0].
- R7: The pointer-adjust output of a destination follows map_ptr_adj of the selected channel, one cycle later, only when the group code is 5. For every other selector it is 0.
- R8: Error flags stay set until software writes a 1 to their bit at address 14 or 15, and that write clears them. If a clear and a new set fall in the same cycle, the set wins.
- R9: With ds1_clk_sel at 0, the external-port group routes its own clock enables, and ext_clk_out is 0. With ds1_clk_sel at 1, the external-port group routes the demultiplexer's clock enable of the same channel number, and ext_clk_out shows those demultiplexer clock enables one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Frame-boundary strobe that commits the shadow selectors |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data |
| ds1_clk_sel | input | 1 | External-port clock select (0 own input, 1 demultiplexer clock) |
| src_data | input | 5x29x8 | Source data bytes per group and channel |
| src_clk_en | input | 5x29 | Source clock enables |
| src_rai | input | 5x29 | Source remote alarm indication |
| src_ais | input | 5x29 | Source alarm indication signal |
| src_fsync | input | 5x29 | Source frame sync |
| src_sig | input | 5x29 | Source out-of-band signaling |
| map_ptr_adj | input | 29 | Mapper receive pointer-adjust per channel |
| ext_clk_out | output | 29 | Demultiplexer DS1 clock driven to the external port |
| dst_data | output | 28x8 | Destination data bytes |
| dst_clk_en | output | 28 | Destination clock enables |
| dst_rai | output | 28 | Destination remote alarm indication |
| dst_ais | output | 28 | Destination alarm indication signal |
| dst_fsync | output | 28 | Destination frame sync |
| dst_sig | output | 28 | Destination signaling |
| dst_ptr_adj | output | 28 | Destination pointer-adjust |

## Verification
Two pairs of events can land in the same cycle. A selector write can coincide with the frame tick, and a software clear of an error flag can coincide with a tick that commits the same illegal selector again. The bench provokes the first by writing a register word in the very cycle it raises frame_tick. The scoreboard then expects the new route on the cycle after that tick. For the second, the bench writes a 1 to the error bit together with a tick while the loop selector is still in the shadow copy, and a later read must show the flag still set. In all other cycles the scoreboard predicts every destination lane from its own model of the selectors and compares it one cycle after the drive.

// File: rtl/trib_xpoint_pkg.sv
package trib_xpoint_pkg;

    localparam int N_GRP  = 5;
    localparam int WORD_W = 16;

    localparam logic [2:0] GRP_EXT = 3'd1;
    localparam logic [2:0] GRP_FRM = 3'd2;
    localparam logic [2:0] GRP_DMX = 3'd3;
    localparam logic [2:0] GRP_TPG = 3'd4;
    localparam logic [2:0] GRP_MAP = 3'd5;
    localparam logic [2:0] GRP_JAT = 3'd6;

    typedef struct packed {
        logic [7:0] data;
        logic       clk_en;
        logic       rai;
        logic       ais;
        logic       fsync;
        logic       sig;
    } bundle_t;

    typedef struct packed {
        bundle_t b;
        logic    ptr;
    } lane_out_t;

    localparam bundle_t IDLE_BUNDLE = '{data: 8'hFF, clk_en: 1'b0, rai: 1'b0,
                                        ais: 1'b1, fsync: 1'b0, sig: 1'b0};

endpackage

// File: rtl/xp_cfg_regs.sv
module xp_cfg_regs
    import trib_xpoint_pkg::*;
#(
    parameter int N_DST  = 28,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_tick,
    input  logic                  cfg_wr,
    input  logic                  cfg_rd,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [WORD_W-1:0]     cfg_wdata,
    output logic [WORD_W-1:0]     cfg_rdata,
    output logic [N_DST-1:0][7:0] active_o
);

    localparam int N_REG    = N_DST / 2;
    localparam int ERR_W    = (N_DST + WORD_W - 1) / WORD_W;
    localparam int ERR_BASE = N_REG;

    typedef struct packed {
        logic [N_DST-1:0][7:0] shadow;
        logic [N_DST-1:0][7:0] active;
        logic [N_DST-1:0]      err;
        logic [WORD_W-1:0]     rdata;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic       clr_hit;

    always_comb begin
        s_d     = s_q;
        clr_hit = 1'b0;

        // read path returns the state before this cycle's updates
        s_d.rdata = '0;
        if (cfg_rd) begin
            for (int r = 0; r < N_REG; r++) begin
                if (cfg_addr == ADDR_W'(r)) begin
                    s_d.rdata = {s_q.shadow[2*r+1], s_q.shadow[2*r]};
                end
            end
            for (int w = 0; w < ERR_W; w++) begin
                if (cfg_addr == ADDR_W'(ERR_BASE + w)) begin
                    for (int b = 0; b < WORD_W; b++) begin
                        if (w * WORD_W + b < N_DST) begin
                            s_d.rdata[b] = s_q.err[w*WORD_W+b];
                        end
                    end
                end
            end
        end

        if (cfg_wr) begin
            for (int r = 0; r < N_REG; r++) begin
                if (cfg_addr == ADDR_W'(r)) begin
                    s_d.shadow[2*r]   = cfg_wdata[7:0];
                    s_d.shadow[2*r+1] = cfg_wdata[15:8];
                end
            end
            for (int w = 0; w < ERR_W; w++) begin
                if (cfg_addr == ADDR_W'(ERR_BASE + w)) begin
                    clr_hit = 1'b1;
                    for (int b = 0; b < WORD_W; b++) begin
                        if ((w * WORD_W + b < N_DST) && cfg_wdata[b]) begin
                            s_d.err[w*WORD_W+b] = 1'b0;
                        end
                    end
                end
            end
        end

        // commit on the frame boundary; a loop selector flags its channel
        if (frame_tick) begin
            s_d.active = s_d.shadow;
            for (int d = 0; d < N_DST; d++) begin
                if (s_d.shadow[d][7:5] == GRP_JAT) begin
                    s_d.err[d] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_rdata = s_q.rdata;
    assign active_o  = s_q.active;

    AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(s_q.active)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((s_q.err & $past(s_q.err)) == $past(s_q.err))); // R8

endmodule

// File: rtl/xp_lane.sv
module xp_lane
    import trib_xpoint_pkg::*;
#(
    parameter int N_SRC_CH = 29
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [7:0]                          sel_i,
    input  bundle_t [N_GRP-1:0][N_SRC_CH-1:0]   src_i,
    input  logic [N_SRC_CH-1:0]                 ptr_i,
    output lane_out_t                           out_o
);

    logic [2:0] code;
    logic [4:0] chn;
    logic       conn;
    lane_out_t  out_d, out_q;

    always_comb begin
        code      = sel_i[7:5];
        chn       = sel_i[4:0];
        conn      = (code >= GRP_EXT) && (code <= GRP_MAP) &&
                    (chn != 5'd0) && (int'(chn) <= N_SRC_CH);
        out_d.b   = IDLE_BUNDLE;
        out_d.ptr = 1'b0;
        if (conn) begin
            out_d.b   = src_i[code-3'd1][chn-5'd1];
            out_d.ptr = (code == GRP_MAP) && ptr_i[chn-5'd1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{b: IDLE_BUNDLE, ptr: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign out_o = out_q;

    AST_UNCONN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !conn |=> (out_q.b.ais && (out_q.b.data == 8'hFF) && !out_q.b.clk_en && !out_q.ptr)); // R5

    AST_PTR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i[7:5] != GRP_MAP) |=> !out_q.ptr); // R7

endmodule

// File: rtl/trib_xpoint.sv
module trib_xpoint
    import trib_xpoint_pkg::*;
#(
    parameter int N_DST    = 28,
    parameter int N_SRC_CH = 29
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 frame_tick,
    input  logic                                 cfg_wr,
    input  logic                                 cfg_rd,
    input  logic [3:0]                           cfg_addr,
    input  logic [15:0]                          cfg_wdata,
    output logic [15:0]                          cfg_rdata,
    input  logic                                 ds1_clk_sel,
    input  logic [N_GRP-1:0][N_SRC_CH-1:0][7:0]  src_data,
    input  logic [N_GRP-1:0][N_SRC_CH-1:0]       src_clk_en,
    input  logic [N_GRP-1:0][N_SRC_CH-1:0]       src_rai,
    input  logic [N_GRP-1:0][N_SRC_CH-1:0]       src_ais,
    input  logic [N_GRP-1:0][N_SRC_CH-1:0]       src_fsync,
    input  logic [N_GRP-1:0][N_SRC_CH-1:0]       src_sig,
    input  logic [N_SRC_CH-1:0]                  map_ptr_adj,
    output logic [N_SRC_CH-1:0]                  ext_clk_out,
    output logic [N_DST-1:0][7:0]                dst_data,
    output logic [N_DST-1:0]                     dst_clk_en,
    output logic [N_DST-1:0]                     dst_rai,
    output logic [N_DST-1:0]                     dst_ais,
    output logic [N_DST-1:0]                     dst_fsync,
    output logic [N_DST-1:0]                     dst_sig,
    output logic [N_DST-1:0]                     dst_ptr_adj
);

    localparam int EXT_IX = int'(GRP_EXT) - 1;
    localparam int DMX_IX = int'(GRP_DMX) - 1;

    bundle_t [N_GRP-1:0][N_SRC_CH-1:0] src_b;
    logic    [N_DST-1:0][7:0]          active;
    lane_out_t                         lane_q [N_DST];
    logic    [N_SRC_CH-1:0]            ext_clk_d, ext_clk_q;

    always_comb begin
        for (int g = 0; g < N_GRP; g++) begin
            for (int c = 0; c < N_SRC_CH; c++) begin
                src_b[g][c] = '{data: src_data[g][c], clk_en: src_clk_en[g][c],
                                rai: src_rai[g][c], ais: src_ais[g][c],
                                fsync: src_fsync[g][c], sig: src_sig[g][c]};
            end
        end
        ext_clk_d = '0;
        if (ds1_clk_sel) begin
            ext_clk_d = src_clk_en[DMX_IX];
            for (int c = 0; c < N_SRC_CH; c++) begin
                src_b[EXT_IX][c].clk_en = src_clk_en[DMX_IX][c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_clk_q <= '0;
        end else begin
            ext_clk_q <= ext_clk_d;
        end
    end

    assign ext_clk_out = ext_clk_q;

    xp_cfg_regs #(.N_DST(N_DST), .ADDR_W(4)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .active_o   (active)
    );

    for (genvar d = 0; d < N_DST; d++) begin : g_lane
        xp_lane #(.N_SRC_CH(N_SRC_CH)) i_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_i (active[d]),
            .src_i (src_b),
            .ptr_i (map_ptr_adj),
            .out_o (lane_q[d])
        );
        assign dst_data[d]    = lane_q[d].b.data;
        assign dst_clk_en[d]  = lane_q[d].b.clk_en;
        assign dst_rai[d]     = lane_q[d].b.rai;
        assign dst_ais[d]     = lane_q[d].b.ais;
        assign dst_fsync[d]   = lane_q[d].b.fsync;
        assign dst_sig[d]     = lane_q[d].b.sig;
        assign dst_ptr_adj[d] = lane_q[d].ptr;
    end

    AST_EXT_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ds1_clk_sel |=> (ext_clk_out == '0)); // R9

    AST_EXT_CLK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ds1_clk_sel |=> (ext_clk_out == $past(src_clk_en[DMX_IX]))); // R9

endmodule

// File: tb/test_trib_xpoint.sv
`timescale 1ns/1ps
module test_trib_xpoint;
    import trib_xpoint_pkg::*;

    localparam int ND = 28;
    localparam int NC = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0, cfg_wr = 1'b0, cfg_rd = 1'b0, ds1_clk_sel = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [N_GRP-1:0][NC-1:0][7:0] src_data = '0;
    logic [N_GRP-1:0][NC-1:0] src_clk_en = '0, src_rai = '0, src_ais = '0, src_fsync = '0, src_sig = '0;
    logic [NC-1:0] map_ptr_adj = '0;
    logic [NC-1:0] ext_clk_out;
    logic [ND-1:0][7:0] dst_data;
    logic [ND-1:0] dst_clk_en, dst_rai, dst_ais, dst_fsync, dst_sig, dst_ptr_adj;

    always #4 clk = ~clk;

    trib_xpoint #(.N_DST(ND), .N_SRC_CH(NC)) i_trib_xpoint (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ds1_clk_sel(ds1_clk_sel), .src_data(src_data), .src_clk_en(src_clk_en),
        .src_rai(src_rai), .src_ais(src_ais), .src_fsync(src_fsync), .src_sig(src_sig),
        .map_ptr_adj(map_ptr_adj), .ext_clk_out(ext_clk_out), .dst_data(dst_data),
        .dst_clk_en(dst_clk_en), .dst_rai(dst_rai), .dst_ais(dst_ais), .dst_fsync(dst_fsync),
        .dst_sig(dst_sig), .dst_ptr_adj(dst_ptr_adj)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        logic [13:0] exp [ND];
        string       ltag [ND];
        logic [NC-1:0] ext;
        bit          rd_v;
        logic [15:0] rd_exp;
        string       rtag;
        longint      due;
    } item_t;

    item_t q [$];

    logic [7:0]  m_shadow [ND];
    logic [7:0]  m_active [ND];
    logic [ND-1:0] m_err;

    function automatic logic [7:0] pat_data(int g, int c, int cy);
        return 8'((g * 37 + c * 11 + cy * 5) % 256);
    endfunction
    function automatic logic pat_clk(int g, int c, int cy);  return ((g + c + cy) % 2) == 1; endfunction
    function automatic logic pat_rai(int g, int c, int cy);  return ((g * c + cy) % 3) == 0; endfunction
    function automatic logic pat_ais(int g, int c, int cy);  return ((g + 2 * c + cy) % 5) == 0; endfunction
    function automatic logic pat_fs(int c, int cy);          return ((c + cy) % 4) == 0; endfunction
    function automatic logic pat_sig(int g, int c, int cy);  return ((g + 3 * c + cy) % 2) == 1; endfunction
    function automatic logic pat_ptr(int c, int cy);         return ((c + cy) % 3) == 0; endfunction

    // expected lane: {data, clk_en, rai, ais, fsync, sig, ptr}
    function automatic logic [13:0] exp_lane(logic [7:0] s, int cy, bit csel);
        int g = int'(s[7:5]);
        int c = int'(s[4:0]);
        logic ck;
        if (g < 1 || g > 5 || c < 1 || c > NC) return {8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
        ck = (g == 1 && csel) ? pat_clk(3, c, cy) : pat_clk(g, c, cy);
        return {pat_data(g, c, cy), ck, pat_rai(g, c, cy), pat_ais(g, c, cy),
                pat_fs(c, cy), pat_sig(g, c, cy), (g == 5) ? pat_ptr(c, cy) : 1'b0};
    endfunction

    function automatic string lane_tag(logic [7:0] s, bit pend);
        int g = int'(s[7:5]);
        int c = int'(s[4:0]);
        if (pend) return "R4";
        if (g == 6) return "R6";
        if (g < 1 || g > 5 || c < 1 || c > NC) return "R5";
        if (g == 5) return "R7";
        if (g == 1) return "R9";
        return "R3";
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].due == $time) begin
                item_t it;
                logic [13:0] got;
                it = q.pop_front();
                for (int d = 0; d < ND; d++) begin
                    got = {dst_data[d], dst_clk_en[d], dst_rai[d], dst_ais[d],
                           dst_fsync[d], dst_sig[d], dst_ptr_adj[d]};
                    n_chk++;
                    if (got !== it.exp[d]) begin
                        n_fail++;
                        $display("FAIL %s dest %0d: got %h expected %h", it.ltag[d], d, got, it.exp[d]);
                    end
                end
                n_chk++;
                if (ext_clk_out !== it.ext) begin
                    n_fail++;
                    $display("FAIL R9 ext_clk_out: got %h expected %h", ext_clk_out, it.ext);
                end
                if (it.rd_v) begin
                    n_chk++;
                    if (cfg_rdata !== it.rd_exp) begin
                        n_fail++;
                        $display("FAIL %s read: got %h expected %h", it.rtag, cfg_rdata, it.rd_exp);
                    end
                end
            end
        end
    end

    task automatic step(input bit wr, input bit rd, input logic [3:0] addr,
                        input logic [15:0] wd, input bit tick, input bit csel, input string rtag);
        item_t it;
        @(negedge clk);
        cyc++;
        cfg_wr = wr; cfg_rd = rd; cfg_addr = addr; cfg_wdata = wd;
        frame_tick = tick; ds1_clk_sel = csel;
        for (int g = 0; g < N_GRP; g++) begin
            for (int c = 0; c < NC; c++) begin
                src_data[g][c]   = pat_data(g + 1, c + 1, cyc);
                src_clk_en[g][c] = pat_clk(g + 1, c + 1, cyc);
                src_rai[g][c]    = pat_rai(g + 1, c + 1, cyc);
                src_ais[g][c]    = pat_ais(g + 1, c + 1, cyc);
                src_fsync[g][c]  = pat_fs(c + 1, cyc);
                src_sig[g][c]    = pat_sig(g + 1, c + 1, cyc);
            end
        end
        for (int c = 0; c < NC; c++) map_ptr_adj[c] = pat_ptr(c + 1, cyc);

        for (int d = 0; d < ND; d++) begin
            it.exp[d]  = exp_lane(m_active[d], cyc, csel);
            it.ltag[d] = lane_tag(m_active[d], m_shadow[d] != m_active[d]);
        end
        for (int c = 0; c < NC; c++) it.ext[c] = csel ? pat_clk(3, c + 1, cyc) : 1'b0;
        it.rd_v = rd;
        it.rtag = rtag;
        it.rd_exp = '0;
        if (int'(addr) < ND / 2) it.rd_exp = {m_shadow[2*addr+1], m_shadow[2*addr]};
        else if (addr == 4'd14) it.rd_exp = m_err[15:0];
        else if (addr == 4'd15) it.rd_exp = {4'h0, m_err[27:16]};
        it.due = $time + 8;
        q.push_back(it);

        if (wr) begin
            if (int'(addr) < ND / 2) begin
                m_shadow[2*addr]   = wd[7:0];
                m_shadow[2*addr+1] = wd[15:8];
            end else if (addr == 4'd14) begin
                for (int b = 0; b < 16; b++) if (wd[b]) m_err[b] = 1'b0;
            end else begin
                for (int b = 0; b < 12; b++) if (wd[b]) m_err[16+b] = 1'b0;
            end
        end
        if (tick) begin
            for (int d = 0; d < ND; d++) begin
                m_active[d] = m_shadow[d];
                if (m_shadow[d][7:5] == 3'd6) m_err[d] = 1'b1;
            end
        end
    endtask

    task automatic idle(input int n, input bit csel);
        for (int i = 0; i < n; i++) step(0, 0, 4'd0, 16'h0, 0, csel, "R3");
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int d = 0; d < ND; d++) begin m_shadow[d] = '0; m_active[d] = '0; end
        m_err = '0;
        repeat (3) @(negedge clk);
        // R1: state while in reset
        for (int d = 0; d < ND; d++) begin
            n_chk++;
            if ({dst_data[d], dst_clk_en[d], dst_rai[d], dst_ais[d], dst_fsync[d], dst_sig[d], dst_ptr_adj[d]}
                !== 14'b11111111_0_0_1_0_0_0) begin
                n_fail++;
                $display("FAIL R1 dest %0d reset: got %h expected %h", d, dst_data[d], 8'hFF);
            end
        end
        n_chk++;
        if (cfg_rdata !== 16'h0 || ext_clk_out !== '0) begin
            n_fail++;
            $display("FAIL R1 rdata/ext: got %h/%h expected 0/0", cfg_rdata, ext_clk_out);
        end
        rst_n = 1'b1;
        step(0, 1, 4'd5, 16'h0, 0, 0, "R1");
        idle(2, 0);

        // R2: configure; R4: no change before the tick
        step(1, 0, 4'd0,  16'h5D21, 0, 0, "R2");
        step(1, 0, 4'd1,  16'h9C65, 0, 0, "R2");
        step(1, 0, 4'd2,  16'hC2A3, 0, 0, "R2");
        step(1, 0, 4'd3,  16'hE120, 0, 0, "R2");
        step(1, 1, 4'd4,  16'h453E, 0, 0, "R2");
        step(1, 0, 4'd8,  16'hA1C1, 0, 0, "R2");
        step(1, 0, 4'd13, 16'hBD01, 0, 0, "R2");
        step(0, 1, 4'd0,  16'h0, 0, 0, "R2");
        step(0, 1, 4'd2,  16'h0, 0, 0, "R2");
        step(0, 1, 4'd13, 16'h0, 0, 0, "R2");
        step(0, 1, 4'd8,  16'h0, 0, 0, "R2");
        idle(3, 0);
        step(0, 0, 4'd0, 16'h0, 1, 0, "R4");
        idle(8, 0);

        // R6: loop selectors flagged
        step(0, 1, 4'd14, 16'h0, 0, 0, "R6");
        step(0, 1, 4'd15, 16'h0, 0, 0, "R6");

        // R9: external port clock from demultiplexer
        idle(6, 1);
        idle(2, 0);

        // R4: write and tick in the same cycle
        step(1, 0, 4'd0, 16'hA53D, 1, 0, "R4");
        idle(5, 0);

        // R8: clear, then clear coinciding with a re-set
        step(1, 0, 4'd14, 16'h0020, 0, 0, "R8");
        step(0, 1, 4'd14, 16'h0, 0, 0, "R8");
        step(1, 0, 4'd15, 16'h0001, 0, 0, "R8");
        step(0, 1, 4'd15, 16'h0, 0, 0, "R8");
        step(1, 0, 4'd14, 16'h0020, 1, 0, "R8");
        step(0, 1, 4'd14, 16'h0, 0, 0, "R8");
        step(0, 1, 4'd15, 16'h0, 0, 0, "R8");

        // mixed traffic
        for (int i = 0; i < 80; i++) begin
            logic [15:0] w;
            w = 16'((i * 16'h3B17 + 16'h1234) ^ (i << 9));
            step((i % 3) == 0, (i % 5) == 1, 4'(i % 16), w, (i % 7) == 6, ((i / 13) % 2) == 1, "R2");
        end
        idle(3, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule